// File: doc/BRIEF.md
# Open-Drain I2C Byte Master

This block is a single-master I2C controller that runs one bus operation per command. A host gives one of four commands: START, WRITE, READ or STOP. The block then moves the two bus lines through a fixed series of steps. It never drives a line high. Each line has an active-high enable that pulls the pad low. Otherwise the block only reads the pad input, through a synchronizer. A programmable number of system clocks, `QTR`, separates every line transition. This sets the SCL rate. Whenever the block lets SCL go, it waits until the line actually reads high, so a target can stretch the clock.

Before a START, the block clears a stuck bus. While SDA reads low, it pulses SCL, up to nine times. If SDA is still low after that, it reports a bus error and leaves the bus idle.

The block does not take an acknowledge choice from the host. After a READ, SCL stays held low. The next command decides the acknowledge:
- Another READ clocks an ACK.
- A STOP or a START clocks a NAK.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, busy, done, nack and bus_error are 0, rd_data is 0, and both line enables are 0 (both lines released).
- R2: The command codes are 0 = START, 1 = WRITE, 2 = READ, 3 = STOP. A command is taken on a clock where cmd_valid is 1 and busy is 0. busy reads 1 from the next cycle until the command ends. done is a single-cycle pulse with busy already 0. A cmd_valid given while busy is 1 is dropped and causes no bus activity.
- R3: The SDA enable changes while SCL is released only to make a start condition (SDA falls) or a stop condition (SDA rises). No other SDA edge occurs with SCL high.
- R4: START on a free bus releases both lines, pulls SDA low while SCL is high, then pulls SCL low. It ends with both lines held low and bus_error 0.
- R5: If SDA reads low at START, SCL is pulsed low-then-released until SDA reads high. The start condition then follows, so k pulses precede it when the target lets go after k pulses.
- R6: If SDA still reads low after nine recovery pulses, bus_error becomes 1 with done, and no start condition is made. bus_error clears at the next START.
- R7: WRITE sends wr_data MSB first, one bit per SCL high phase. On the ninth clock it releases SDA and samples it. A low sample leaves nack at 0. The command ends with SCL released.
- R8: A high sample on the ninth clock of a WRITE sets nack to 1 on the done pulse. nack clears when the next WRITE is taken.
- R9: READ samples 8 bits MSB first on SCL high phases. rd_data holds the byte on the done pulse. SCL is left held low afterwards.
- R10: A READ that follows a READ holds SDA low during one SCL high phase before the new data bits. This is the ACK for the earlier byte.
- R11: STOP first releases SDA and then SCL. After a READ, this clocks SDA high (a NAK). It then pulls SCL low, pulls SDA low, releases SCL and finally releases SDA. The result is one stop condition, with both lines free at the end.
- R12: The quarter-period count starts only once SCL reads high. Each SCL high phase therefore lasts at least `QTR` cycles, and a target that holds SCL low delays the command by the held time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 2 | Command code (0 START, 1 WRITE, 2 READ, 3 STOP) |
| wr_data | input | 8 | Byte to send with WRITE |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| nack | output | 1 | Last WRITE was not acknowledged |
| bus_error | output | 1 | Bus-clear recovery failed at START |
| rd_data | output | 8 | Byte received by the last READ |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
- **Status outputs.** busy rises one cycle after the clock edge that takes a command. done, nack, bus_error and rd_data all change on the same edge that ends the command. The bench therefore drives on falling clock edges, checks busy at the first falling edge after the request, and reads every status output at the falling edge where done is seen. It then confirms that done has dropped one cycle later.
- **Bus results.** Bus activity lags the enables by the two-stage synchronizer plus one quarter period. So the bench does not predict cycle numbers for line edges. Instead, edge monitors on the modelled open-drain bus log the SDA value at each SCL rise, count start and stop conditions, and measure SCL high phases in clock cycles. These logs are checked after done.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } i2c_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  // Open-drain: a data bit of 0 needs the pull-down enabled.
  function automatic logic pull_for(input logic bit_val);
    return ~bit_val;
  endfunction

  // True when the bit index has reached the last bit of a byte.
  function automatic logic final_bit(input logic [2:0] idx);
    return idx == 3'd0;
  endfunction

endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
  parameter int QTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stall,
  output logic expire
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  assign expire = run && !stall && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || stall || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int QTR         = 4,
  parameter int CLR_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       done,
  output logic       nack,
  output logic       bus_error,
  output logic [7:0] rd_data,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CLR_W = $clog2(CLR_PULSES + 1);
  localparam logic [CLR_W-1:0] CLR_LAST = CLR_W'(CLR_PULSES);

  seq_state_e       state;
  i2c_cmd_e         op;
  logic [3:0]       step;
  logic [2:0]       bitn;
  logic [CLR_W-1:0] clr_cnt;
  logic [7:0]       shreg;
  logic [1:0]       pins_s;

  // Named internal events, used by the bound checker.
  logic scl_s, sda_s, wait_phase, qtr_exp, scl_stretched, cond_step;

  i2c_pin_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  assign wait_phase    = (state == ST_WAIT);
  assign scl_stretched = !scl_oe && !scl_s;

  i2c_qtr_timer #(.QTR(QTR)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_phase), .stall(scl_stretched),
    .expire(qtr_exp)
  );

  assign cond_step = (state == ST_RUN) &&
                     (((op == CMD_START) && (step == 4'd1) && sda_s) ||
                      ((op == CMD_STOP)  && (step == 4'd5)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op        <= CMD_START;
      step      <= '0;
      bitn      <= '0;
      clr_cnt   <= '0;
      shreg     <= '0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      nack      <= 1'b0;
      bus_error <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op      <= i2c_cmd_e'(cmd);
            step    <= 4'd0;
            bitn    <= 3'd7;
            clr_cnt <= '0;
            shreg   <= wr_data;
            busy    <= 1'b1;
            state   <= ST_RUN;
            if (cmd == CMD_START) bus_error <= 1'b0;
            if (cmd == CMD_WRITE) nack      <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (qtr_exp) state <= ST_RUN;
        end
        default: begin
          state <= ST_WAIT;
          case (op)
            CMD_START: begin
              case (step)
                4'd0: begin scl_oe <= 1'b0; sda_oe <= 1'b0; step <= 4'd1; end
                4'd1: begin
                  if (sda_s) begin
                    sda_oe <= 1'b1; step <= 4'd3;
                  end else if (clr_cnt == CLR_LAST) begin
                    bus_error <= 1'b1; busy <= 1'b0; done <= 1'b1; state <= ST_IDLE;
                  end else begin
                    scl_oe <= 1'b1; clr_cnt <= clr_cnt + 1'b1; step <= 4'd2;
                  end
                end
                4'd2: begin scl_oe <= 1'b0; step <= 4'd1; end
                4'd3: begin scl_oe <= 1'b1; step <= 4'd4; end
                default: begin busy <= 1'b0; done <= 1'b1; state <= ST_IDLE; end
              endcase
            end
            CMD_WRITE: begin
              case (step)
                4'd0: begin scl_oe <= 1'b1; step <= 4'd1; end
                4'd1: begin sda_oe <= pull_for(shreg[7]); step <= 4'd2; end
                4'd2: begin scl_oe <= 1'b0; step <= 4'd3; end
                4'd3: begin
                  shreg <= {shreg[6:0], 1'b0};
                  state <= ST_RUN;
                  if (final_bit(bitn)) step <= 4'd4;
                  else begin bitn <= bitn - 3'd1; step <= 4'd0; end
                end
                4'd4: begin scl_oe <= 1'b1; step <= 4'd5; end
                4'd5: begin sda_oe <= 1'b0; step <= 4'd6; end
                4'd6: begin scl_oe <= 1'b0; step <= 4'd7; end
                default: begin
                  nack <= sda_s; busy <= 1'b0; done <= 1'b1; state <= ST_IDLE;
                end
              endcase
            end
            CMD_READ: begin
              case (step)
                4'd0: begin
                  if (scl_oe) begin sda_oe <= 1'b1; step <= 4'd1; end
                  else        begin scl_oe <= 1'b1; step <= 4'd3; end
                end
                4'd1: begin scl_oe <= 1'b0; step <= 4'd2; end
                4'd2: begin scl_oe <= 1'b1; step <= 4'd3; end
                4'd3: begin sda_oe <= 1'b0; step <= 4'd4; end
                4'd4: begin scl_oe <= 1'b0; step <= 4'd5; end
                4'd5: begin
                  shreg  <= {shreg[6:0], sda_s};
                  scl_oe <= 1'b1;
                  if (final_bit(bitn)) step <= 4'd6;
                  else begin bitn <= bitn - 3'd1; step <= 4'd4; end
                end
                default: begin
                  rd_data <= shreg; busy <= 1'b0; done <= 1'b1; state <= ST_IDLE;
                end
              endcase
            end
            default: begin
              case (step)
                4'd0: begin sda_oe <= 1'b0; step <= 4'd1; end
                4'd1: begin scl_oe <= 1'b0; step <= 4'd2; end
                4'd2: begin scl_oe <= 1'b1; step <= 4'd3; end
                4'd3: begin sda_oe <= 1'b1; step <= 4'd4; end
                4'd4: begin scl_oe <= 1'b0; step <= 4'd5; end
                4'd5: begin sda_oe <= 1'b0; step <= 4'd6; end
                default: begin busy <= 1'b0; done <= 1'b1; state <= ST_IDLE; end
              endcase
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       busy,
  input logic       done,
  input logic       nack,
  input logic       bus_error,
  input logic [7:0] rd_data,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       wait_phase,
  input logic       cond_step
);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(scl_oe)) |-> $past(cond_step));

  // R12
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_phase && !scl_oe && !scl_s) |=> wait_phase);

  // R6
  bus_error_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_error) |-> done);

  // R8
  nack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> done);

  // R9
  rd_data_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .nack(nack), .bus_error(bus_error), .rd_data(rd_data), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .scl_s(scl_s), .wait_phase(wait_phase), .cond_step(cond_step)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam int QTR = 4;
  localparam int STR = 40;
  localparam logic [1:0] C_START = 2'd0, C_WRITE = 2'd1, C_READ = 2'd2, C_STOP = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic busy, done, nack, bus_error, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic scl_bus, sda_bus;

  // Target model state
  logic slv_low = 1'b0;
  logic slv_hold = 1'b0;
  logic str_en = 1'b0;
  logic [63:0] slv_pat = '0;
  int fall_idx = 0, rise_idx = 0, start_cnt = 0, stop_cnt = 0;
  int cyc = 0, rise_cyc = 0, min_high = 1000000;
  logic rise_seen = 1'b0;
  logic rise_log [32];
  int checks = 0, errors = 0, base_dur = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign scl_bus = ~scl_oe & ~slv_hold;
  assign sda_bus = ~sda_oe & ~slv_low;

  i2c_cmd_master #(.QTR(QTR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .wr_data(wr_data),
    .busy(busy), .done(done), .nack(nack), .bus_error(bus_error), .rd_data(rd_data),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge scl_bus) begin
    int f;
    if (rise_seen && (cyc - rise_cyc) < min_high) min_high = cyc - rise_cyc;
    f = fall_idx;
    fall_idx++;
    #1 slv_low = (f < 64) ? slv_pat[f] : 1'b0;
  end

  always @(negedge scl_bus) begin
    if (str_en) begin
      slv_hold = 1'b1;
      repeat (STR) @(posedge clk);
      slv_hold = 1'b0;
    end
  end

  always @(posedge scl_bus) begin
    if (rise_idx < 32) rise_log[rise_idx] = sda_bus;
    rise_idx++;
    rise_cyc = cyc;
    rise_seen = 1'b1;
  end

  always @(negedge sda_bus) if (scl_bus === 1'b1) start_cnt++;
  always @(posedge sda_bus) if (scl_bus === 1'b1) stop_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arm(input logic [63:0] pat, input logic init_low);
    slv_pat = pat;
    slv_low = init_low;
    #1;
    fall_idx = 0; rise_idx = 0; start_cnt = 0; stop_cnt = 0;
    rise_seen = 1'b0; min_high = 1000000;
  endtask

  function automatic logic [63:0] data_pat(input logic [7:0] d);
    logic [63:0] p = '0;
    for (int i = 0; i < 8; i++) p[i] = ~d[7-i];
    return p;
  endfunction

  function automatic logic [7:0] logged_byte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = rise_log[base+i];
    return b;
  endfunction

  task automatic wait_done(output int dur);
    dur = 1;
    while (!done && dur < 20000) begin @(negedge clk); dur++; end
    chk("R2 done seen", done, 1'b1);
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [7:0] d, output int dur);
    @(negedge clk); cmd = c; wr_data = d; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    wait_done(dur);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 nack", nack, 0);
    chk("R1 bus_error", bus_error, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_start_clean;
    int d;
    arm('0, 1'b0);
    run_cmd(C_START, 8'h00, d);
    chk("R4 bus_error", bus_error, 0);
    chk("R4 start count", start_cnt, 1);
    chk("R4 scl falls", fall_idx, 1);
    chk("R4 scl held low", scl_bus, 0);
    chk("R4 sda held low", sda_bus, 0);
  endtask

  task automatic t_write_ack(input logic [7:0] d);
    int dur;
    arm(64'h80, 1'b0);
    run_cmd(C_WRITE, d, dur);
    base_dur = dur;
    chk("R7 byte MSB first", logged_byte(0), d);
    chk("R7 ninth clock sees ack", rise_log[8], 0);
    chk("R7 nack clear", nack, 0);
    chk("R7 scl released", scl_bus, 1);
    chk("R12 high phase >= QTR", min_high >= QTR, 1);
  endtask

  task automatic t_write_nack_busy;
    int dur, extra;
    arm('0, 1'b1);
    @(negedge clk); cmd = C_WRITE; wr_data = 8'h3C; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R2 busy after accept", busy, 1);
    repeat (5) @(negedge clk);
    cmd = C_READ; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    wait_done(dur);
    chk("R8 nack set", nack, 1);
    chk("R7 byte 0x3C", logged_byte(0), 8'h3C);
    @(negedge clk);
    chk("R2 done one cycle", done, 0);
    extra = 0;
    repeat (200) begin @(negedge clk); if (done) extra++; end
    chk("R2 ignored cmd no done", extra, 0);
    chk("R2 ignored cmd no clocks", rise_idx, 9);
    chk("R2 idle", busy, 0);
  endtask

  task automatic t_stop_after_write;
    int d;
    arm('0, 1'b0);
    run_cmd(C_STOP, 8'h00, d);
    chk("R11 stop count", stop_cnt, 1);
    chk("R3 no start during stop", start_cnt, 0);
    chk("R11 lines free", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_bus_clear;
    int d;
    arm(64'h3, 1'b1);
    run_cmd(C_START, 8'h00, d);
    chk("R5 no bus_error", bus_error, 0);
    chk("R5 pulses plus start fall", fall_idx, 4);
    chk("R5 one start", start_cnt, 1);
  endtask

  task automatic t_reads;
    int d;
    arm(64'h80, 1'b0);
    run_cmd(C_WRITE, 8'h91, d);
    chk("R7 addr acked", nack, 0);
    arm(data_pat(8'hC6), 1'b1);
    run_cmd(C_READ, 8'h00, d);
    chk("R9 first byte", rd_data, 8'hC6);
    chk("R9 scl held low", scl_bus, 0);
    chk("R9 eight clocks", rise_idx, 8);
    arm(data_pat(8'h3B), 1'b0);
    run_cmd(C_READ, 8'h00, d);
    chk("R10 ack clocked low", rise_log[0], 0);
    chk("R9 second byte", rd_data, 8'h3B);
    chk("R9 bits on bus", logged_byte(1), 8'h3B);
    arm('0, 1'b0);
    run_cmd(C_STOP, 8'h00, d);
    chk("R11 nak clocked high", rise_log[0], 1);
    chk("R11 stop after read", stop_cnt, 1);
    chk("R3 no stray start", start_cnt, 0);
    chk("R11 lines free", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_stretch;
    int d, dur;
    arm('0, 1'b0);
    run_cmd(C_START, 8'h00, d);
    arm(64'h80, 1'b0);
    str_en = 1'b1;
    run_cmd(C_WRITE, 8'h5A, dur);
    str_en = 1'b0;
    chk("R12 byte under stretch", logged_byte(0), 8'h5A);
    chk("R12 ack under stretch", nack, 0);
    chk("R12 delayed by stretch", dur >= base_dur + 8 * (STR - 4 * QTR), 1);
    chk("R12 high phase >= QTR", min_high >= QTR, 1);
    arm('0, 1'b0);
    run_cmd(C_STOP, 8'h00, d);
    chk("R11 stop after stretch", stop_cnt, 1);
  endtask

  task automatic t_bus_error;
    int d;
    arm('1, 1'b1);
    run_cmd(C_START, 8'h00, d);
    chk("R6 bus_error", bus_error, 1);
    chk("R6 nine pulses", fall_idx, 9);
    chk("R6 no start", start_cnt, 0);
    chk("R6 scl released", scl_bus, 1);
    slv_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_start_clean();
    t_write_ack(8'hA5);
    t_write_nack_busy();
    t_stop_after_write();
    t_bus_clear();
    t_reads();
    t_stretch();
    t_bus_error();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule